// File: doc/BRIEF.md
# Isolated I/O Port Interface

This block sits between a processor bus and up to eight character devices that live in an I/O space kept apart from memory. The bus carries a device number, a data byte, read and write strobes and one control line that marks the cycle as an I/O cycle. A memory cycle on the same wires is ignored by the block.

Each device slot has its own decoder, an input byte register with a "character waiting" flag, and an output byte register with a "ready for next character" flag. The device side loads the input register with a strobe and takes the output byte with a strobe. The processor reads and writes these registers, and it can read a status byte that shows both flags and a sticky overrun flag. The flags stop a character from being read twice and stop a pending output character from being overwritten.

The device number has two fields. Bits [2:0] pick the slot. Bit 3 picks the status byte when it is 1 and the data register when it is 0. Read data is combinational and appears in the same cycle as the read strobe. Register updates take effect at the next rising clock edge.

Top module: `isolated_io_port`

## Requirements
- R1: When `bus_io` is 0 (memory cycle), no port register or flag changes because of the bus. In that cycle `bus_rdata` is 0 and `bus_drive` is 0.
- R2: Only the slot whose number equals `bus_dev[2:0]` responds to an I/O read or write. Every other slot is left unchanged.
- R3: An I/O read with `bus_dev[3]`=0 drives the selected slot's input register onto `bus_rdata` and sets `bus_drive` to 1 in the same cycle.
- R4: A pulse on `dev_in_load[i]` stores byte i of `dev_in_data` in slot i. At the next edge it also sets the input flag, which is seen on `dev_in_full[i]`.
- R5: An I/O data read of a slot clears that slot's input flag at the next edge.
- R6: If a load and a data read of the same slot happen in the same cycle, the flag stays 1 and the register holds the new byte.
- R7: An I/O write with `bus_dev[3]`=0 to a slot that is ready stores `bus_wdata` and clears the ready flag. From the next cycle `dev_out_valid[i]`=1 and byte i of `dev_out_data` equals the written byte.
- R8: A pulse on `dev_out_take[i]` while slot i has a byte pending sets the ready flag again, so `dev_out_valid[i]` becomes 0 at the next edge.
- R9: A data write to a slot that is not ready is ignored. The pending byte is kept and the slot's sticky overrun flag is set.
- R10: An I/O read with `bus_dev[3]`=1 returns the status byte: bit 0 is the input flag, bit 1 is the ready flag, bit 2 is overrun, and all other bits are 0. The read clears overrun at the next edge, unless an ignored write sets it again in the same cycle. The read does not clear the input flag.
- R11: In an I/O cycle without a read, `bus_rdata` is 0 and `bus_drive` is 0.
- R12: A write with `bus_dev[3]`=1 changes no register or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_io | input | 1 | 1 marks an I/O cycle, 0 marks a memory cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_dev | input | 4 | Slot number in [2:0]; bit 3 selects the status byte |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, 0 when not driven |
| bus_drive | output | 1 | Drive enable for the read byte |
| dev_in_load | input | 8 | Per-slot input load strobe |
| dev_in_data | input | 64 | Per-slot input bytes, slot i in bits [8i+7:8i] |
| dev_in_full | output | 8 | Per-slot input flag |
| dev_out_take | input | 8 | Per-slot output taken strobe |
| dev_out_data | output | 64 | Per-slot output bytes |
| dev_out_valid | output | 8 | Per-slot output pending, the inverse of the ready flag |

## Verification
Read results (`bus_rdata`, `bus_drive`) are combinational. The bench drives inputs just after a falling edge and samples them 1 ns later, before the next rising edge. Flag and register effects go through one register, so the bench samples them 1 ns after that rising edge and compares them with a model that it updates at the same edge. Overrun cannot be seen directly, so it is checked through status reads. The results of those reads are due in their own cycle and reflect every earlier edge.

// File: rtl/isolated_io_port.sv
module isolated_io_port #(
  parameter int NDEV   = 8,
  parameter int DW     = 8,
  parameter int ADDR_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_io,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [ADDR_W:0]      bus_dev,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  output logic                 bus_drive,
  input  logic [NDEV-1:0]      dev_in_load,
  input  logic [NDEV*DW-1:0]   dev_in_data,
  output logic [NDEV-1:0]      dev_in_full,
  input  logic [NDEV-1:0]      dev_out_take,
  output logic [NDEV*DW-1:0]   dev_out_data,
  output logic [NDEV-1:0]      dev_out_valid
);
  logic [NDEV-1:0] sel;
  logic [DW-1:0]   rd_vec [NDEV];
  wire             stat_sel = bus_dev[ADDR_W];

  for (genvar i = 0; i < NDEV; i++) begin : g_slot
    logic [DW-1:0] in_q, out_q;
    logic          full_q, rdy_q, ovr_q;

    assign sel[i] = bus_io && (bus_dev[ADDR_W-1:0] == ADDR_W'(i));
    wire rd_dat = sel[i] && bus_rd && !stat_sel;
    wire rd_st  = sel[i] && bus_rd &&  stat_sel;
    wire wr_dat = sel[i] && bus_wr && !stat_sel;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        in_q   <= '0;
        full_q <= 1'b0;
      end else if (dev_in_load[i]) begin
        in_q   <= dev_in_data[i*DW +: DW];
        full_q <= 1'b1;
      end else if (rd_dat) begin
        full_q <= 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_q <= '0;
        rdy_q <= 1'b1;
        ovr_q <= 1'b0;
      end else begin
        if (wr_dat && rdy_q) begin
          out_q <= bus_wdata;
          rdy_q <= 1'b0;
        end else if (dev_out_take[i]) begin
          rdy_q <= 1'b1;
        end
        if (wr_dat && !rdy_q) ovr_q <= 1'b1;
        else if (rd_st)       ovr_q <= 1'b0;
      end
    end

    assign rd_vec[i] = rd_dat ? in_q :
                       rd_st  ? {{(DW-3){1'b0}}, ovr_q, rdy_q, full_q} : '0;
    assign dev_in_full[i]             = full_q;
    assign dev_out_valid[i]           = !rdy_q;
    assign dev_out_data[i*DW +: DW]   = out_q;
  end

  always_comb begin
    bus_rdata = '0;
    for (int k = 0; k < NDEV; k++) bus_rdata |= rd_vec[k];
  end

  assign bus_drive = bus_io && bus_rd;
endmodule

module isolated_io_port_chk #(
  parameter int NDEV = 8,
  parameter int DW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_io,
  input logic            bus_drive,
  input logic [DW-1:0]   bus_rdata,
  input logic [NDEV-1:0] dev_in_load,
  input logic [NDEV-1:0] dev_in_full,
  input logic [NDEV-1:0] dev_out_take,
  input logic [NDEV-1:0] dev_out_valid,
  input logic [NDEV-1:0] sel
);
  p_mem_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_io && dev_in_load == '0 && dev_out_take == '0)
      |=> ($stable(dev_in_full) && $stable(dev_out_valid)));

  p_one_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel) && (bus_io || sel == '0));

  p_load_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_in_load != '0) |=> ((dev_in_full & $past(dev_in_load)) == $past(dev_in_load)));

  p_pending_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((dev_out_valid & ~dev_out_take) != '0)
      |=> ((dev_out_valid & $past(dev_out_valid & ~dev_out_take))
           == $past(dev_out_valid & ~dev_out_take)));

  p_quiet_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_drive |-> (bus_rdata == '0));
endmodule

bind isolated_io_port isolated_io_port_chk #(.NDEV(NDEV), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_io(bus_io), .bus_drive(bus_drive),
  .bus_rdata(bus_rdata), .dev_in_load(dev_in_load), .dev_in_full(dev_in_full),
  .dev_out_take(dev_out_take), .dev_out_valid(dev_out_valid), .sel(sel)
);

// File: tb/tb_isolated_io_port.sv
`timescale 1ns/1ps
module tb_isolated_io_port;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_io = 0, bus_rd = 0, bus_wr = 0;
  logic [3:0]  bus_dev = 0;
  logic [7:0]  bus_wdata = 0, bus_rdata;
  logic        bus_drive;
  logic [7:0]  dev_in_load = 0, dev_in_full, dev_out_take = 0, dev_out_valid;
  logic [63:0] dev_in_data = 0, dev_out_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] m_in [8], m_out [8];
  bit m_full [8], m_rdy [8], m_ovr [8];

  always #2.5 clk = ~clk;

  isolated_io_port dut (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(bit io, bit rd, logic [3:0] dev);
    if (!(io && rd)) return 8'h00;
    if (dev[3]) return {5'b0, m_ovr[dev[2:0]], m_rdy[dev[2:0]], m_full[dev[2:0]]};
    return m_in[dev[2:0]];
  endfunction

  function automatic logic [7:0] vec_full();
    for (int i = 0; i < 8; i++) vec_full[i] = m_full[i];
  endfunction

  function automatic logic [7:0] vec_valid();
    for (int i = 0; i < 8; i++) vec_valid[i] = !m_rdy[i];
  endfunction

  function automatic logic [63:0] vec_out();
    for (int i = 0; i < 8; i++) vec_out[i*8 +: 8] = m_out[i];
  endfunction

  task automatic step(bit io, bit rd, bit wr, logic [3:0] dev, logic [7:0] wd,
                      logic [7:0] lmask, logic [63:0] ldata, logic [7:0] tmask, string tag);
    string rtag;
    @(negedge clk);
    bus_io = io; bus_rd = rd; bus_wr = wr; bus_dev = dev; bus_wdata = wd;
    dev_in_load = lmask; dev_in_data = ldata; dev_out_take = tmask;
    #1;
    rtag = !io ? "R1" : (!rd ? "R11" : (dev[3] ? "R10" : "R3"));
    chk({tag, " rdata ", rtag}, {56'b0, bus_rdata}, {56'b0, exp_read(io, rd, dev)});
    chk({tag, " drive ", rtag}, {63'b0, bus_drive}, {63'b0, io && rd});
    @(posedge clk);
    for (int i = 0; i < 8; i++) begin
      bit s   = io && (dev[2:0] == 3'(i));
      bit rdd = s && rd && !dev[3];
      bit rds = s && rd && dev[3];
      bit wrd = s && wr && !dev[3];
      if (lmask[i]) begin m_in[i] = ldata[i*8 +: 8]; m_full[i] = 1; end
      else if (rdd) m_full[i] = 0;
      if (wrd && !m_rdy[i]) m_ovr[i] = 1;
      else if (rds) m_ovr[i] = 0;
      if (wrd && m_rdy[i]) begin m_out[i] = wd; m_rdy[i] = 0; end
      else if (tmask[i]) m_rdy[i] = 1;
    end
    #1;
    chk({tag, " in_full R4 R5 R6 R2"}, {56'b0, dev_in_full}, {56'b0, vec_full()});
    chk({tag, " out_valid R7 R8 R9 R12"}, {56'b0, dev_out_valid}, {56'b0, vec_valid()});
    chk({tag, " out_data R7 R9"}, dev_out_data, vec_out());
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) begin
      m_in[i] = 0; m_out[i] = 0; m_full[i] = 0; m_rdy[i] = 1; m_ovr[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    chk("reset in_full", {56'b0, dev_in_full}, 64'h0);
    chk("reset out_valid", {56'b0, dev_out_valid}, 64'h0);
    chk("reset rdata", {56'b0, bus_rdata}, 64'h0);
    @(negedge clk); rst_n = 1;

    step(1, 0, 0, 4'h6, 8'h00, 8'h40, 64'h0041_0000_0000_0000, 8'h00, "R4 load slot6");
    step(0, 1, 0, 4'h6, 8'h00, 8'h00, 64'h0, 8'h00, "R1 memory read");
    step(0, 0, 1, 4'h6, 8'h99, 8'h00, 64'h0, 8'h00, "R1 memory write");
    step(1, 1, 0, 4'h6, 8'h00, 8'h00, 64'h0, 8'h00, "R3 R5 read slot6");
    step(1, 1, 0, 4'h6, 8'h00, 8'h00, 64'h0, 8'h00, "R5 reread slot6");
    step(1, 0, 0, 4'h2, 8'h00, 8'h04, 64'h0000_0000_0011_0000, 8'h00, "R4 load slot2");
    step(1, 1, 0, 4'h2, 8'h00, 8'h04, 64'h0000_0000_0022_0000, 8'h00, "R6 load+read slot2");
    step(1, 1, 0, 4'hA, 8'h00, 8'h00, 64'h0, 8'h00, "R10 status slot2");
    step(1, 0, 1, 4'h3, 8'h5A, 8'h00, 64'h0, 8'h00, "R7 write slot3");
    step(1, 0, 1, 4'h3, 8'h77, 8'h00, 64'h0, 8'h00, "R9 write busy slot3");
    step(1, 1, 0, 4'hB, 8'h00, 8'h00, 64'h0, 8'h00, "R10 status overrun");
    step(1, 1, 0, 4'hB, 8'h00, 8'h00, 64'h0, 8'h00, "R10 status cleared");
    step(1, 0, 1, 4'h3, 8'h66, 8'h00, 64'h0, 8'h00, "R9 busy again");
    step(1, 1, 1, 4'hB, 8'h00, 8'h00, 64'h0, 8'h00, "R12 R10 status write+read");
    step(1, 0, 0, 4'h3, 8'h00, 8'h00, 64'h0, 8'h08, "R8 take slot3");
    step(1, 0, 1, 4'hB, 8'hFF, 8'h00, 64'h0, 8'h00, "R12 status write");
    step(1, 0, 1, 4'h5, 8'hC3, 8'h00, 64'h0, 8'h00, "R2 write slot5 only");
    step(1, 0, 0, 4'h0, 8'h00, 8'h00, 64'h0, 8'h00, "R11 idle io");

    for (int n = 0; n < 4000; n++) begin
      bit io = ($urandom % 4) != 0;
      int op = $urandom % 4;
      logic [7:0] lm = 8'($urandom) & 8'($urandom) & 8'($urandom);
      logic [7:0] tm = 8'($urandom) & 8'($urandom);
      step(io, op == 1, op == 2 || op == 3, 4'($urandom), 8'($urandom), lm,
           {$urandom, $urandom}, tm, "random R2");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule